// File: doc/BRIEF.md
# Programmable Qualified Event Counter

This block is one programmable performance counter for a shared cache and memory-request fabric. Each clock it receives a handful of parallel event lanes: cache lookups, each tagged with the line state it found and the kind of request behind it, and cross-core snoop responses, each tagged with a response kind and the place the snoop came from. It also receives a level giving the number of outstanding memory requests. Software chooses one event family with an 8-bit event code and narrows it with an 8-bit unit mask. The block turns the inputs into a per-cycle event count and adds the result to a 48-bit counter.

Between the count and the counter sits a qualifier. A nonzero threshold turns the count into a one-cycle yes/no decision: the count is at least the threshold, or, with invert set, strictly below it. An optional edge stage then passes only the cycle in which that decision turns from false to true. Software writes the configuration and the counter through a two-entry register interface and reads either entry back through a combinational read port.

Top module: `qualified_event_counter`

## Requirements
- R1: After reset the counter and every configuration field are zero, and both register entries read as zero.
- R2: With a zero threshold and edge clear, the counter grows each cycle by the full per-cycle count of selected events, so several events in one cycle add more than one. With a zero threshold the invert bit has no effect.
- R3: With a nonzero threshold and invert clear, the counter grows by exactly one in a cycle whose event count is greater than or equal to the threshold, and by zero otherwise.
- R4: With a nonzero threshold and invert set, the counter grows by exactly one in a cycle whose event count is strictly less than the threshold, and by zero otherwise.
- R5: With edge set, the qualified condition is the threshold decision, or "count is nonzero" when the threshold is zero. The counter grows by one only in a cycle where that condition is true and was false in the previous enabled cycle.
- R6: While the run bit is clear the counter holds its value. The stored previous condition of the edge stage is cleared, so the first enabled cycle with a true condition counts.
- R7: Register entry 0 holds the configuration: event code in bits 7:0, unit mask in 15:8, threshold in 23:16, edge in bit 24, invert in bit 25, run in bit 26. Entry 1 is the counter. A write to entry 1 loads the value at the next edge and discards that cycle's increment. Both entries read back what was written. The counter wraps modulo 2^48.
- R8: Event code 0x34 counts lookup lanes. The lane state code (0 M, 1 E, 2 S, 3 I) must have its mask bit set (bits 0 to 3). If any of mask bits 7:4 is set, the request type code (0 read, 1 write, 2 external snoop, 3 other) must match: bit 4 read, bit 5 write, bit 6 external snoop, bit 7 any type. A mask with no state bit counts nothing.
- R9: Event code 0x22 counts snoop lanes. The response kind code 0 to 4 (miss, invalidate-clean, hit-clean, hit-modified, invalidate-modified) must have mask bit 0 to 4 set; kind codes 5 to 7 never count. If any of mask bits 7:5 is set, the origin code (0 external, 1 cross-core, 2 eviction) must have mask bit 5 to 7 set; origin code 3 then never counts.
- R10: Event code 0x80 with mask bit 0 set adds the outstanding-request level as the per-cycle count.
- R11: Any other event code, or an all-zero unit mask, gives a per-cycle count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write entry: 0 configuration, 1 counter |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 1 | Read entry: 0 configuration, 1 counter |
| rdData | output | CNT_W | Combinational read data |
| lkValid | input | LANES | Lookup lane valid bits |
| lkState | input | 2*LANES | Per-lane line state code |
| lkType | input | 2*LANES | Per-lane request type code |
| snValid | input | LANES | Snoop lane valid bits |
| snKind | input | 3*LANES | Per-lane snoop response kind code |
| snOrigin | input | 2*LANES | Per-lane snoop origin code |
| occLevel | input | OCC_W | Number of outstanding requests this cycle |

## Verification
Random lane traffic, covering every state, type, kind and origin code including the invalid ones, is run under lookup masks with and without type filters, snoop masks with and without origin filters, and the occupancy level. The per-cycle counter delta then separates a miscounted lane from a wrong filter polarity. The same traffic under thresholds, inversion and edge mode separates "at least", "strictly less" and "first cycle only". A filter-only mask, a zero mask and an unknown code must leave the counter frozen. A constant occupancy level with edge mode on checks that disabling the counter re-arms the edge stage. A counter write with events present, and a near-full counter fed by occupancy, cover the discarded increment and the wrap.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [7:0] CODE_SNOOP  = 8'h22;
  localparam logic [7:0] CODE_LOOKUP = 8'h34;
  localparam logic [7:0] CODE_OCC    = 8'h80;

  typedef struct packed {
    logic       runEn;
    logic       invEn;
    logic       edgeEn;
    logic [7:0] cMask;
    logic [7:0] uMask;
    logic [7:0] evSel;
  } cfg_t;

  typedef struct packed {
    logic cntLoad;
    logic cntRun;
    logic edgeClr;
  } strobe_t;

  function automatic int cntWidth(int lanes, int occW);
    int laneW;
    laneW = $clog2(lanes + 1);
    return (laneW > occW) ? laneW : occW;
  endfunction
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [26:0]      cfgData,
  input  logic             rdAddr,
  input  logic [CNT_W-1:0] cntValue,
  output evt_pkg::cfg_t    cfg,
  output evt_pkg::strobe_t strobes,
  output logic [CNT_W-1:0] rdData
);
  evt_pkg::cfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (wrEn && !wrAddr) begin
      cfgQ <= '{runEn:  cfgData[26],
                invEn:  cfgData[25],
                edgeEn: cfgData[24],
                cMask:  cfgData[23:16],
                uMask:  cfgData[15:8],
                evSel:  cfgData[7:0]};
    end
  end

  always_comb begin
    strobes.cntLoad = wrEn && wrAddr;
    strobes.cntRun  = cfgQ.runEn;
    strobes.edgeClr = !cfgQ.runEn;
  end

  assign cfg = cfgQ;

  always_comb begin
    if (rdAddr) rdData = cntValue;
    else rdData = CNT_W'({cfgQ.runEn, cfgQ.invEn, cfgQ.edgeEn,
                          cfgQ.cMask, cfgQ.uMask, cfgQ.evSel});
  end

  // R7: a configuration write is visible on the read port one cycle later
  assert_cfg_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr) |=> (cfgQ.uMask == $past(cfgData[15:8]) && cfgQ.runEn == $past(cfgData[26])));
endmodule

// File: rtl/evt_sel.sv
module evt_sel #(
  parameter int LANES = 4,
  parameter int OCC_W = 5,
  parameter int EV_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         evSel,
  input  logic [7:0]         uMask,
  input  logic [LANES-1:0]   lkValid,
  input  logic [2*LANES-1:0] lkState,
  input  logic [2*LANES-1:0] lkType,
  input  logic [LANES-1:0]   snValid,
  input  logic [3*LANES-1:0] snKind,
  input  logic [2*LANES-1:0] snOrigin,
  input  logic [OCC_W-1:0]   occLevel,
  output logic [EV_W-1:0]    evCount
);
  logic [LANES-1:0] lkHit;
  logic [LANES-1:0] snHit;
  logic [EV_W-1:0]  lkSum;
  logic [EV_W-1:0]  snSum;
  logic             typeFree;
  logic             originFree;

  assign typeFree   = (uMask[7:4] == 4'd0);
  assign originFree = (uMask[7:5] == 3'd0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] st;
    logic [1:0] ty;
    logic [2:0] kind;
    logic [1:0] org;
    logic       typeOk;
    logic       originOk;
    assign st   = lkState[2*i +: 2];
    assign ty   = lkType[2*i +: 2];
    assign kind = snKind[3*i +: 3];
    assign org  = snOrigin[2*i +: 2];
    // request type code t maps to mask bit 4+t; bit 7 also matches every type
    assign typeOk   = typeFree || uMask[7] || uMask[{1'b1, ty}];
    assign originOk = originFree || ((org != 2'd3) && uMask[3'd5 + {1'b0, org}]);
    assign lkHit[i] = lkValid[i] && uMask[{1'b0, st}] && typeOk;
    assign snHit[i] = snValid[i] && (kind <= 3'd4) && uMask[kind] && originOk;
  end

  always_comb begin
    lkSum = '0;
    snSum = '0;
    for (int i = 0; i < LANES; i++) begin
      lkSum = lkSum + EV_W'(lkHit[i]);
      snSum = snSum + EV_W'(snHit[i]);
    end
  end

  always_comb begin
    case (evSel)
      evt_pkg::CODE_LOOKUP: evCount = lkSum;
      evt_pkg::CODE_SNOOP:  evCount = snSum;
      evt_pkg::CODE_OCC:    evCount = uMask[0] ? EV_W'(occLevel) : '0;
      default:              evCount = '0;
    endcase
  end

  // R8: a lookup mask without any state bit yields nothing
  assert_filter_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evSel == evt_pkg::CODE_LOOKUP && uMask[3:0] == 4'd0) |-> (evCount == '0));
  // R11: an empty mask yields nothing whatever the lanes carry
  assert_zero_mask_R11: assert property (@(posedge clk) disable iff (!rstN)
    (uMask == 8'd0) |-> (evCount == '0));
  // R9: snoop count never exceeds the number of valid snoop lanes
  assert_snoop_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evSel == evt_pkg::CODE_SNOOP) |-> (32'(evCount) <= $countones(snValid)));
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath #(
  parameter int CNT_W = 48,
  parameter int EV_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  evt_pkg::strobe_t strobes,
  input  logic [7:0]       cMask,
  input  logic             edgeEn,
  input  logic             invEn,
  input  logic [EV_W-1:0]  evCount,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] cntValue
);
  localparam int CMP_W = (EV_W > 8) ? EV_W : 8;

  logic [CMP_W-1:0] countExt;
  logic [CMP_W-1:0] thrExt;
  logic             thrOn;
  logic             condNow;
  logic             prevCond;
  logic [EV_W-1:0]  incr;
  logic [CNT_W-1:0] cntQ;

  assign countExt = CMP_W'(evCount);
  assign thrExt   = CMP_W'(cMask);
  assign thrOn    = (cMask != 8'd0);

  always_comb begin
    if (thrOn) condNow = invEn ? (countExt < thrExt) : (countExt >= thrExt);
    else       condNow = (evCount != '0);
  end

  always_comb begin
    if (!strobes.cntRun)  incr = '0;
    else if (edgeEn)      incr = EV_W'(condNow && !prevCond);
    else if (thrOn)       incr = EV_W'(condNow);
    else                  incr = evCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                prevCond <= 1'b0;
    else if (strobes.edgeClr) prevCond <= 1'b0;
    else                      prevCond <= condNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.cntLoad) cntQ <= loadValue;
    else                      cntQ <= cntQ + CNT_W'(incr);
  end

  assign cntValue = cntQ;

  // R7: a software load lands exactly, with no increment on top
  assert_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntLoad |=> (cntValue == $past(loadValue)));
  // R6: a stopped counter keeps its value
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntRun && !strobes.cntLoad) |=> $stable(cntValue));
  // R3: thresholded or edge modes add at most one per cycle
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntRun && !strobes.cntLoad && (edgeEn || thrOn))
      |=> ((cntValue - $past(cntValue)) <= CNT_W'(1)));
  // R5: an edge pulse is never followed by another in the next cycle
  assert_edge_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEn && incr != '0) |=> (!edgeEn || incr == '0));
endmodule

// File: rtl/qualified_event_counter.sv
module qualified_event_counter #(
  parameter int LANES = 4,
  parameter int OCC_W = 5,
  parameter int CNT_W = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               rdAddr,
  output logic [CNT_W-1:0]   rdData,
  input  logic [LANES-1:0]   lkValid,
  input  logic [2*LANES-1:0] lkState,
  input  logic [2*LANES-1:0] lkType,
  input  logic [LANES-1:0]   snValid,
  input  logic [3*LANES-1:0] snKind,
  input  logic [2*LANES-1:0] snOrigin,
  input  logic [OCC_W-1:0]   occLevel
);
  localparam int EV_W = evt_pkg::cntWidth(LANES, OCC_W);

  evt_pkg::cfg_t    cfg;
  evt_pkg::strobe_t strobes;
  logic [EV_W-1:0]  evCount;
  logic [CNT_W-1:0] cntValue;

  evt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cfgData(wrData[26:0]), .rdAddr(rdAddr), .cntValue(cntValue),
    .cfg(cfg), .strobes(strobes), .rdData(rdData)
  );

  evt_sel #(.LANES(LANES), .OCC_W(OCC_W), .EV_W(EV_W)) u_sel (
    .clk(clk), .rstN(rstN), .evSel(cfg.evSel), .uMask(cfg.uMask),
    .lkValid(lkValid), .lkState(lkState), .lkType(lkType),
    .snValid(snValid), .snKind(snKind), .snOrigin(snOrigin),
    .occLevel(occLevel), .evCount(evCount)
  );

  evt_datapath #(.CNT_W(CNT_W), .EV_W(EV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cMask(cfg.cMask),
    .edgeEn(cfg.edgeEn), .invEn(cfg.invEn), .evCount(evCount),
    .loadValue(wrData), .cntValue(cntValue)
  );
endmodule

// File: tb/qualified_event_counter_tb.sv
`timescale 1ns/1ps
module qualified_event_counter_tb;
  localparam int LANES = 4;
  localparam int OCC_W = 5;
  localparam int CNT_W = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrAddr = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic rdAddr = 1'b1;
  logic [CNT_W-1:0] rdData;
  logic [LANES-1:0] lkValid = '0;
  logic [2*LANES-1:0] lkState = '0;
  logic [2*LANES-1:0] lkType = '0;
  logic [LANES-1:0] snValid = '0;
  logic [3*LANES-1:0] snKind = '0;
  logic [2*LANES-1:0] snOrigin = '0;
  logic [OCC_W-1:0] occLevel = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0] expCnt = '0;
  logic [7:0] mCode = 8'd0, mMask = 8'd0, mThr = 8'd0;
  bit mEdge = 1'b0, mInv = 1'b0, mRun = 1'b0, mPrev = 1'b0;

  always #10 clk = ~clk;

  qualified_event_counter #(.LANES(LANES), .OCC_W(OCC_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lkValid(lkValid), .lkState(lkState),
    .lkType(lkType), .snValid(snValid), .snKind(snKind), .snOrigin(snOrigin),
    .occLevel(occLevel)
  );

  task automatic check(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle count of selected events, from R8..R11
  function automatic int selModel();
    int n = 0;
    case (mCode)
      8'h34: for (int i = 0; i < LANES; i++) begin
        int st = int'(lkState[2*i +: 2]);
        int ty = int'(lkType[2*i +: 2]);
        bit typeOk = (mMask[7:4] == 4'd0) || mMask[7] || mMask[4 + ty];
        if (lkValid[i] && mMask[st] && typeOk) n++;
      end
      8'h22: for (int i = 0; i < LANES; i++) begin
        int kd = int'(snKind[3*i +: 3]);
        int og = int'(snOrigin[2*i +: 2]);
        bit orgOk = (mMask[7:5] == 3'd0) || (og < 3 && mMask[5 + og]);
        if (snValid[i] && kd <= 4 && mMask[kd] && orgOk) n++;
      end
      8'h80: if (mMask[0]) n = int'(occLevel);
      default: n = 0;
    endcase
    return n;
  endfunction

  task automatic cycle(input bit we, input bit wa, input logic [CNT_W-1:0] wd, input string tag);
    int n;
    bit cond;
    logic [CNT_W-1:0] inc;
    wrEn = we; wrAddr = wa; wrData = wd;
    n = selModel();
    if (mThr != 0) cond = mInv ? (n < int'(mThr)) : (n >= int'(mThr));
    else cond = (n != 0);
    inc = '0;
    if (mRun) begin
      if (mEdge) inc = CNT_W'(cond && !mPrev);
      else if (mThr != 0) inc = CNT_W'(cond);
      else inc = CNT_W'(n);
    end
    mPrev = mRun ? cond : 1'b0;
    if (we && wa) expCnt = wd;
    else expCnt = expCnt + inc;
    if (we && !wa) {mRun, mInv, mEdge, mThr, mMask, mCode} = wd[26:0];
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    rdAddr = 1'b1;
    #1;
    check(rdData, expCnt, tag);
  endtask

  task automatic randInputs();
    lkValid = LANES'($urandom);
    lkState = (2*LANES)'($urandom);
    lkType = (2*LANES)'($urandom);
    snValid = LANES'($urandom);
    snKind = (3*LANES)'($urandom);
    snOrigin = (2*LANES)'($urandom);
    occLevel = OCC_W'($urandom);
  endtask

  task automatic quietInputs(input logic [OCC_W-1:0] occ);
    lkValid = '0; snValid = '0; occLevel = occ;
  endtask

  task automatic configure(input logic [7:0] code, input logic [7:0] mask, input logic [7:0] thr,
                           input bit ed, input bit iv, input bit run, input string tag);
    logic [CNT_W-1:0] word;
    word = CNT_W'({run, iv, ed, thr, mask, code});
    cycle(1'b1, 1'b0, word, tag);
    rdAddr = 1'b0;
    #1;
    check(rdData, word, "R7 configuration readback");
    rdAddr = 1'b1;
  endtask

  task automatic runPhase(input logic [7:0] code, input logic [7:0] mask, input logic [7:0] thr,
                          input bit ed, input bit iv, input bit run, input int n, input string tag);
    configure(code, mask, thr, ed, iv, run, tag);
    repeat (n) begin
      randInputs();
      cycle(1'b0, 1'b0, '0, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    rdAddr = 1'b1; #1; check(rdData, '0, "R1 counter after reset");
    rdAddr = 1'b0; #1; check(rdData, '0, "R1 configuration after reset");
    rdAddr = 1'b1;

    // R8 lookup masks, with and without type filters
    runPhase(8'h34, 8'h0F, 8'd0, 0, 0, 1, 300, "R8 lookup all states");
    runPhase(8'h34, 8'h16, 8'd0, 0, 0, 1, 300, "R8 lookup E/S reads");
    runPhase(8'h34, 8'h69, 8'd0, 0, 0, 1, 300, "R8 lookup M/I write+snoop");
    runPhase(8'h34, 8'h84, 8'd0, 0, 0, 1, 200, "R8 lookup any-type filter");
    runPhase(8'h34, 8'hF0, 8'd0, 0, 0, 1, 100, "R8 filter-only mask counts nothing");
    // R9 snoop masks
    runPhase(8'h22, 8'h1F, 8'd0, 0, 0, 1, 300, "R9 snoop all kinds");
    runPhase(8'h22, 8'h2A, 8'd0, 0, 0, 1, 300, "R9 snoop external origin");
    runPhase(8'h22, 8'hD5, 8'd0, 0, 0, 1, 300, "R9 snoop cross-core/eviction");
    // R10 and R2 occupancy, invert ignored at zero threshold
    runPhase(8'h80, 8'h01, 8'd0, 0, 0, 1, 300, "R10 occupancy adds level");
    runPhase(8'h80, 8'h01, 8'd0, 0, 1, 1, 200, "R2 invert ignored at zero threshold");
    // R11
    runPhase(8'h55, 8'hFF, 8'd0, 0, 0, 1, 100, "R11 unknown code");
    runPhase(8'h34, 8'h00, 8'd0, 0, 0, 1, 100, "R11 zero mask");
    runPhase(8'h80, 8'h02, 8'd0, 0, 0, 1, 100, "R11 occupancy without bit 0");
    // R3 / R4 thresholds
    runPhase(8'h34, 8'h0F, 8'd2, 0, 0, 1, 300, "R3 threshold 2 lookup");
    runPhase(8'h80, 8'h01, 8'd17, 0, 0, 1, 300, "R3 threshold 17 occupancy");
    runPhase(8'h22, 8'h1F, 8'd2, 0, 1, 1, 300, "R4 inverted threshold 2");
    runPhase(8'h80, 8'h01, 8'd9, 0, 1, 1, 300, "R4 inverted threshold 9");
    // R5 edge
    runPhase(8'h34, 8'h0F, 8'd0, 1, 0, 1, 300, "R5 edge on nonzero count");
    runPhase(8'h80, 8'h01, 8'd20, 1, 0, 1, 300, "R5 edge on threshold");
    runPhase(8'h80, 8'h01, 8'd12, 1, 1, 1, 300, "R5 edge on inverted threshold");
    // R6 stopped counter
    runPhase(8'h34, 8'h0F, 8'd0, 0, 0, 0, 200, "R6 stopped counter holds");

    // R5/R6 directed: constant true condition, disable re-arms the edge stage
    quietInputs(OCC_W'(10));
    configure(8'h80, 8'h01, 8'd1, 1, 0, 1, "R5 edge directed setup");
    repeat (6) cycle(1'b0, 1'b0, '0, "R5 steady condition adds once");
    configure(8'h80, 8'h01, 8'd1, 1, 0, 0, "R6 disable clears edge state");
    cycle(1'b0, 1'b0, '0, "R6 disabled hold");
    configure(8'h80, 8'h01, 8'd1, 1, 0, 1, "R6 re-enable");
    repeat (4) cycle(1'b0, 1'b0, '0, "R6 re-armed edge counts once");

    // R7 load discards the increment, then wrap
    configure(8'h80, 8'h01, 8'd0, 0, 0, 1, "R7 occupancy setup");
    quietInputs(OCC_W'(7));
    cycle(1'b1, 1'b1, 48'h0000_1234_5678, "R7 load discards increment");
    cycle(1'b0, 1'b0, '0, "R7 count after load");
    quietInputs(OCC_W'(5));
    cycle(1'b1, 1'b1, 48'hFFFF_FFFF_FFFE, "R7 load near full");
    cycle(1'b0, 1'b0, '0, "R7 wraps modulo 2^48");
    check(rdData, 48'd3, "R7 wrapped value");
    repeat (200) begin
      randInputs();
      if (($urandom % 10) == 0) cycle(1'b1, 1'b1, {16'($urandom), 32'($urandom)}, "R7 random load");
      else cycle(1'b0, 1'b0, '0, "R10 random occupancy after loads");
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule